// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block runs one general-purpose DMA channel. Software programs a control word, a 16-bit transfer count and two 20-bit linear addresses (source and destination) through a simple register write port. Once the channel is running, the block issues one transfer at a time to a bus agent over a request/acknowledge handshake. It presents the source and destination addresses and the transfer size with each request. After each acknowledged transfer it steps both addresses and counts down the remaining transfers.

The block decides when the channel starts and stops, and when an interrupt pulse is raised. An unsynchronized channel runs freely. A synchronized channel (paced by the source or by the destination) moves data only while its request input is high. With the terminal-count bit clear, a synchronized channel runs until software stops it. Issue pauses, without losing any state, while the bus is held, a refresh is under way, a request of equal or higher priority is pending, or the global halt is asserted.

Top module: `dma_chan_seq`

## Requirements
- R1: After each acknowledged transfer, `count_left` drops by one if it was non-zero. At zero it stays at zero. The count is 0 after reset.
- R2: When a transfer takes the count from 1 to 0 and either the terminal-count bit is set or the channel is unsynchronized, `active` clears. Further requests are then ignored, so no more transfers are issued.
- R3: When a transfer takes the count from 1 to 0 and the interrupt-enable bit is set, `irq` is high for exactly one cycle. This happens whatever the terminal-count bit holds and whether or not the channel stops.
- R4: A control write sets `active` to control bit 0 at any time. A write to the count register while the auto-start bit is set also sets `active`. With auto-start clear, a count write leaves `active` unchanged.
- R5: A running channel issues transfers only while the count is non-zero, or while the terminal-count bit is 0 and the channel is synchronized. Otherwise `active` clears one cycle after it was set, and no transfer is issued.
- R6: A synchronized channel with the terminal-count bit at 0 keeps issuing transfers while its request input is high, also once the count is 0. It stops only when software writes control bit 0 as 0. A transfer that does not change the count from 1 to 0 raises no `irq`.
- R7: No transfer is issued in a cycle where `hold`, `refresh`, `prio_pend` or `halt` is high. For a synchronized channel, none is issued while `dreq` is low. Paused transfers resume later with count and addresses intact.
- R8: When the I/O-space bit of an address is set, that address is driven on the bus with its upper 4 bits as zero.
- R9: After each transfer, the source and destination addresses each step by the size (1 for byte, 2 for word) according to their own 2-bit mode: 0 or 3 hold, 1 increment, 2 decrement. The arithmetic wraps modulo 2^20.
- R10: `bus_req` is held with stable `bus_src`, `bus_dst` and `bus_word` until `bus_ack` is seen. The following transfer uses the updated addresses.
- R11: Register index `wr_addr`: 0 control, 1 count, 2 source low 16 bits, 3 source upper 4 bits (data bits 3:0), 4 destination low 16 bits, 5 destination upper 4 bits. The control bits are: 0 run, 1 terminal-count, 2 interrupt-enable, 3 auto-start, 5:4 pacing (0 unsynchronized, 1 source-synchronized, 2 destination-synchronized, 3 treated as synchronized), 7:6 source step, 9:8 destination step, 10 source I/O space, 11 destination I/O space, 12 word size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index |
| wr_data | input | 16 | Register write data |
| dreq | input | 1 | Request line pacing a synchronized channel |
| hold | input | 1 | Bus hold in progress |
| refresh | input | 1 | Refresh cycle in progress |
| prio_pend | input | 1 | Equal or higher priority request pending |
| halt | input | 1 | Global DMA halt |
| bus_req | output | 1 | Transfer request to the bus agent |
| bus_src | output | 20 | Source address of the current transfer |
| bus_dst | output | 20 | Destination address of the current transfer |
| bus_word | output | 1 | Current transfer is a word (else byte) |
| bus_ack | input | 1 | Bus agent completed the transfer |
| irq | output | 1 | One-cycle interrupt pulse |
| active | output | 1 | Channel run bit |
| count_left | output | 16 | Remaining transfer count |

## Verification
The hardest state to reach is a synchronized channel with terminal count disabled that has already counted down to zero. It must keep transferring and must raise its interrupt only on the one transfer that reached zero. The stimulus programs a count of two, holds the request line high for several dozen cycles and counts transfers and interrupt pulses. It then writes the run bit low and confirms that no transfer follows. A second hard case is a suspension that arrives between transfers. The stimulus raises each pause source in turn during a long unsynchronized run. The monitor checks that no request rises while any pause source is high, and that the remaining count matches the number of transfers completed.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_UPD  = 2'd2
  } seq_state_e;

  typedef enum logic [2:0] {
    RA_CTRL   = 3'd0,
    RA_COUNT  = 3'd1,
    RA_SRC_LO = 3'd2,
    RA_SRC_HI = 3'd3,
    RA_DST_LO = 3'd4,
    RA_DST_HI = 3'd5
  } reg_addr_e;

  typedef enum logic [1:0] {
    STEP_HOLD  = 2'd0,
    STEP_UP    = 2'd1,
    STEP_DOWN  = 2'd2,
    STEP_HOLDX = 2'd3
  } step_e;

  // control word bits 12:1 (bit 0 is the run bit, kept separately)
  typedef struct packed {
    logic       word;
    logic       dst_io;
    logic       src_io;
    step_e      dst_step;
    step_e      src_step;
    logic [1:0] pacing;
    logic       auto_go;
    logic       irq_en;
    logic       tc_en;
  } ctrl_t;

  localparam int CTRL_W = 12;

endpackage

// File: rtl/dma_addr_reg.sv
module dma_addr_reg
  import dma_seq_pkg::*;
#(
  parameter int AW = 20,
  parameter int LW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [DW-1:0] wr_data,
  input  logic          adv,
  input  step_e         mode,
  input  logic          word,
  input  logic          io,
  output logic [AW-1:0] addr_q,
  output logic [AW-1:0] bus_addr
);
  localparam int HW = AW - LW;

  logic [AW-1:0] delta;
  logic [AW-1:0] stepped;

  always_comb begin
    delta = word ? AW'(2) : AW'(1);
    case (mode)
      STEP_UP:   stepped = addr_q + delta;
      STEP_DOWN: stepped = addr_q - delta;
      default:   stepped = addr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else begin
      if (adv)   addr_q <= stepped;
      if (wr_lo) addr_q[LW-1:0] <= wr_data[LW-1:0];
      if (wr_hi) addr_q[AW-1:LW] <= wr_data[HW-1:0];
    end
  end

  assign bus_addr = io ? {{HW{1'b0}}, addr_q[LW-1:0]} : addr_q;

endmodule

// File: rtl/dma_xfer_counter.sv
module dma_xfer_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [CW-1:0] wr_data,
  input  logic          dec,
  output logic [CW-1:0] cnt_q,
  output logic          is_zero,
  output logic          hit_zero
);
  always_ff @(posedge clk) begin
    if (rst)                      cnt_q <= '0;
    else if (wr)                  cnt_q <= wr_data;
    else if (dec && cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
  end

  assign is_zero  = (cnt_q == '0);
  assign hit_zero = dec && !wr && (cnt_q == CW'(1));

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int AW  = 20,
  parameter int LW  = 16,
  parameter int CW  = 16,
  parameter int DW  = 16,
  parameter int RAW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [RAW-1:0] wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic           dreq,
  input  logic           hold,
  input  logic           refresh,
  input  logic           prio_pend,
  input  logic           halt,
  output logic           bus_req,
  output logic [AW-1:0]  bus_src,
  output logic [AW-1:0]  bus_dst,
  output logic           bus_word,
  input  logic           bus_ack,
  output logic           irq,
  output logic           active,
  output logic [CW-1:0]  count_left
);
  seq_state_e    st_q;
  ctrl_t         ctrl_q;
  logic          run_q, run_d;
  logic          wr_ctrl, wr_count;
  logic          wr_src_lo, wr_src_hi, wr_dst_lo, wr_dst_hi;
  logic          synced, suspend, start_ok, upd;
  logic          cnt_zero, hit_zero;
  logic [AW-1:0] src_q, dst_q, src_bus, dst_bus;
  logic          src_io_q, dst_io_q;

  assign wr_ctrl   = wr_en && (wr_addr == RAW'(RA_CTRL));
  assign wr_count  = wr_en && (wr_addr == RAW'(RA_COUNT));
  assign wr_src_lo = wr_en && (wr_addr == RAW'(RA_SRC_LO));
  assign wr_src_hi = wr_en && (wr_addr == RAW'(RA_SRC_HI));
  assign wr_dst_lo = wr_en && (wr_addr == RAW'(RA_DST_LO));
  assign wr_dst_hi = wr_en && (wr_addr == RAW'(RA_DST_HI));

  assign src_io_q = ctrl_q.src_io;
  assign dst_io_q = ctrl_q.dst_io;

  assign synced   = |ctrl_q.pacing;
  assign suspend  = hold | refresh | prio_pend | halt | (synced & ~dreq);
  assign start_ok = !cnt_zero || (!ctrl_q.tc_en && synced);
  assign upd      = (st_q == ST_UPD);

  dma_xfer_counter #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .wr       (wr_count),
    .wr_data  (wr_data[CW-1:0]),
    .dec      (upd),
    .cnt_q    (count_left),
    .is_zero  (cnt_zero),
    .hit_zero (hit_zero)
  );

  dma_addr_reg #(.AW(AW), .LW(LW), .DW(DW)) u_src (
    .clk      (clk),
    .rst      (rst),
    .wr_lo    (wr_src_lo),
    .wr_hi    (wr_src_hi),
    .wr_data  (wr_data),
    .adv      (upd),
    .mode     (ctrl_q.src_step),
    .word     (ctrl_q.word),
    .io       (ctrl_q.src_io),
    .addr_q   (src_q),
    .bus_addr (src_bus)
  );

  dma_addr_reg #(.AW(AW), .LW(LW), .DW(DW)) u_dst (
    .clk      (clk),
    .rst      (rst),
    .wr_lo    (wr_dst_lo),
    .wr_hi    (wr_dst_hi),
    .wr_data  (wr_data),
    .adv      (upd),
    .mode     (ctrl_q.dst_step),
    .word     (ctrl_q.word),
    .io       (ctrl_q.dst_io),
    .addr_q   (dst_q),
    .bus_addr (dst_bus)
  );

  // run bit: later assignments take priority
  always_comb begin
    run_d = run_q;
    if (st_q == ST_IDLE && run_q && !start_ok)
      run_d = 1'b0;
    if (upd && hit_zero && (ctrl_q.tc_en || !synced))
      run_d = 1'b0;
    if (wr_ctrl)
      run_d = wr_data[0];
    if (wr_count && ctrl_q.auto_go)
      run_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      ctrl_q   <= '0;
      run_q    <= 1'b0;
      bus_req  <= 1'b0;
      bus_src  <= '0;
      bus_dst  <= '0;
      bus_word <= 1'b0;
      irq      <= 1'b0;
    end else begin
      run_q <= run_d;
      irq   <= upd && hit_zero && ctrl_q.irq_en;
      if (wr_ctrl) ctrl_q <= ctrl_t'(wr_data[CTRL_W:1]);
      case (st_q)
        ST_IDLE: begin
          if (run_q && start_ok && !suspend) begin
            st_q     <= ST_REQ;
            bus_req  <= 1'b1;
            bus_src  <= src_bus;
            bus_dst  <= dst_bus;
            bus_word <= ctrl_q.word;
          end
        end
        ST_REQ: begin
          if (bus_ack) begin
            st_q    <= ST_UPD;
            bus_req <= 1'b0;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign active = run_q;

endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
  parameter int AW = 20,
  parameter int LW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          hold,
  input logic          refresh,
  input logic          prio_pend,
  input logic          halt,
  input logic          bus_req,
  input logic          bus_ack,
  input logic [AW-1:0] bus_src,
  input logic [AW-1:0] bus_dst,
  input logic          bus_word,
  input logic          irq,
  input logic [CW-1:0] count_left,
  input logic          src_io,
  input logic          dst_io
);
  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> bus_req);

  p_req_stable_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> ($stable(bus_src) && $stable(bus_dst) && $stable(bus_word)));

  p_no_issue_paused_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> !$past(hold | refresh | prio_pend | halt));

  p_src_io_mask_r8: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_req) && src_io) |-> (bus_src[AW-1:LW] == '0));

  p_dst_io_mask_r8: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_req) && dst_io) |-> (bus_dst[AW-1:LW] == '0));

  p_irq_single_r3: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  p_count_down_r1: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_en) && $past(count_left) != '0 && count_left != $past(count_left))
      |-> (count_left == $past(count_left) - CW'(1)));

  p_count_floor_r1: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_en) && $past(count_left) == '0) |-> (count_left == '0));

endmodule

bind dma_chan_seq dma_chan_seq_chk #(.AW(AW), .LW(LW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .hold       (hold),
  .refresh    (refresh),
  .prio_pend  (prio_pend),
  .halt       (halt),
  .bus_req    (bus_req),
  .bus_ack    (bus_ack),
  .bus_src    (bus_src),
  .bus_dst    (bus_dst),
  .bus_word   (bus_word),
  .irq        (irq),
  .count_left (count_left),
  .src_io     (src_io_q),
  .dst_io     (dst_io_q)
);

// File: tb/sim_dma_chan_seq.sv
`timescale 1ns/1ps
module sim_dma_chan_seq;
  localparam int AW = 20;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [15:0]   wr_data = '0;
  logic          dreq = 1'b0, hold = 1'b0, refresh = 1'b0, prio_pend = 1'b0, halt = 1'b0;
  logic          bus_req, bus_word, irq, active;
  logic [AW-1:0] bus_src, bus_dst;
  logic          bus_ack = 1'b0;
  logic [CW-1:0] count_left;

  always #2.5 clk = ~clk;

  dma_chan_seq u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dreq(dreq), .hold(hold), .refresh(refresh), .prio_pend(prio_pend), .halt(halt),
    .bus_req(bus_req), .bus_src(bus_src), .bus_dst(bus_dst), .bus_word(bus_word),
    .bus_ack(bus_ack), .irq(irq), .active(active), .count_left(count_left)
  );

  int n_chk = 0, n_fail = 0, n_xfer = 0, n_irq = 0;
  logic [AW-1:0] exp_src = '0, exp_dst = '0;
  int  s_step = 0, d_step = 0;
  bit  c_tc, c_ie, c_ag, c_sio, c_dio, c_w;
  int  c_sync, c_ss, c_ds;
  bit  req_prev = 1'b0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] bus_view(input logic [AW-1:0] a, input bit io);
    return io ? {4'h0, a[15:0]} : a;
  endfunction

  function automatic logic [15:0] mk_ctrl(input bit run);
    logic [15:0] v;
    v = '0;
    v[0] = run; v[1] = c_tc; v[2] = c_ie; v[3] = c_ag;
    v[5:4] = c_sync[1:0]; v[7:6] = c_ss[1:0]; v[9:8] = c_ds[1:0];
    v[10] = c_sio; v[11] = c_dio; v[12] = c_w;
    return v;
  endfunction

  // bus agent and monitor, sampling 1 ns after each rising edge
  always begin
    @(posedge clk); #1;
    if (!rst) begin
      if (irq) n_irq++;
      if (bus_req && !req_prev) begin
        n_xfer++;
        check(!(hold | refresh | prio_pend | halt) && (c_sync == 0 || dreq),
              "R7 request issued while paused", 1, 0);
        check(bus_src == bus_view(exp_src, c_sio), "R9 R11 source address (R8 mask)",
              bus_src, bus_view(exp_src, c_sio));
        check(bus_dst == bus_view(exp_dst, c_dio), "R9 R11 destination address (R8 mask)",
              bus_dst, bus_view(exp_dst, c_dio));
        check(bus_word == c_w, "R10 transfer size", bus_word, c_w);
        exp_src = exp_src + AW'(s_step);
        exp_dst = exp_dst + AW'(d_step);
      end
      bus_ack <= bus_req && !bus_ack;
      req_prev = bus_req;
    end
  end

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // stop the channel, program it, then set run
  task automatic go(input logic [AW-1:0] src, input logic [AW-1:0] dst, input logic [15:0] cnt);
    int sz;
    bit ag;
    ag = c_ag; c_ag = 0;
    wr(0, mk_ctrl(0));
    cyc(8);
    c_ag = ag;
    sz = c_w ? 2 : 1;
    s_step = (c_ss == 1) ? sz : (c_ss == 2) ? -sz : 0;
    d_step = (c_ds == 1) ? sz : (c_ds == 2) ? -sz : 0;
    wr(2, src[15:0]); wr(3, {12'h0, src[19:16]});
    wr(4, dst[15:0]); wr(5, {12'h0, dst[19:16]});
    exp_src = src; exp_dst = dst;
    wr(1, cnt);
    wr(0, mk_ctrl(1));
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(5.0 * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    int n0, i0;
    c_tc = 0; c_ie = 0; c_ag = 0; c_sio = 0; c_dio = 0; c_w = 0;
    c_sync = 0; c_ss = 0; c_ds = 0;
    cyc(4);
    rst = 1'b0;
    cyc(1);
    check(count_left == 0, "R1 reset count", count_left, 0);
    check(!bus_req, "R10 reset request", bus_req, 0);
    check(!active && !irq, "R2 R3 reset run/irq", {active, irq}, 0);

    // sweep: size x source step x destination step, unsynchronized, count 3
    for (int w = 0; w < 2; w++)
      for (int ss = 0; ss < 3; ss++)
        for (int ds = 0; ds < 3; ds++) begin
          c_w = w[0]; c_ss = ss; c_ds = ds; c_sync = 0; c_tc = 0; c_ie = 1; c_ag = 0;
          c_sio = w[0]; c_dio = (ss == ds);
          go(20'hFFFFE, 20'h00001, 16'd3);
          n0 = n_xfer; i0 = n_irq;
          cyc(30);
          check(n_xfer - n0 == 3, "R1 R10 transfers for count 3", n_xfer - n0, 3);
          check(count_left == 0, "R1 count after run", count_left, 0);
          check(!active, "R2 unsynchronized stop at zero", active, 0);
          check(n_irq - i0 == 1, "R3 one interrupt", n_irq - i0, 1);
        end

    // R5: start refused with zero count
    c_w = 0; c_ss = 1; c_ds = 1; c_sio = 0; c_dio = 0; c_ie = 1;
    c_sync = 0; c_tc = 0;
    go(20'h12345, 20'h54321, 16'd0);
    n0 = n_xfer; i0 = n_irq;
    cyc(6);
    check(!active, "R5 unsync zero count start refused", active, 0);
    check(n_xfer == n0 && n_irq == i0, "R5 no transfer on refused start", n_xfer - n0, 0);
    c_sync = 1; c_tc = 1; dreq = 1'b1;
    go(20'h12345, 20'h54321, 16'd0);
    n0 = n_xfer;
    cyc(6);
    check(!active, "R5 sync tc zero count start refused", active, 0);
    check(n_xfer == n0, "R5 no transfer sync tc", n_xfer - n0, 0);

    // R6: synchronized, terminal count off, zero count runs until stopped
    c_sync = 1; c_tc = 0; c_ie = 1;
    go(20'h00100, 20'h00200, 16'd0);
    n0 = n_xfer; i0 = n_irq;
    cyc(40);
    check(n_xfer - n0 >= 8, "R6 endless sync transfers", n_xfer - n0, 8);
    check(active, "R6 still running", active, 1);
    check(count_left == 0, "R1 count floor at zero", count_left, 0);
    check(n_irq == i0, "R6 no irq without reaching zero", n_irq - i0, 0);
    wr(0, mk_ctrl(0));
    cyc(6);
    n0 = n_xfer;
    cyc(20);
    check(!active && n_xfer == n0, "R6 software stop", n_xfer - n0, 0);

    // R2: synchronized with terminal count stops and ignores requests
    c_sync = 2; c_tc = 1; c_ie = 0;
    go(20'h00400, 20'h00500, 16'd2);
    n0 = n_xfer; i0 = n_irq;
    cyc(40);
    check(n_xfer - n0 == 2, "R2 sync tc transfer count", n_xfer - n0, 2);
    check(!active, "R2 sync tc stop", active, 0);
    check(n_irq == i0, "R3 no irq when disabled", n_irq - i0, 0);

    // R3: irq while channel keeps running
    c_sync = 1; c_tc = 0; c_ie = 1;
    go(20'h00600, 20'h00700, 16'd2);
    n0 = n_xfer; i0 = n_irq;
    cyc(40);
    check(n_irq - i0 == 1, "R3 irq independent of stop", n_irq - i0, 1);
    check(active && n_xfer - n0 > 2, "R3 channel continues", n_xfer - n0, 3);
    wr(0, mk_ctrl(0));
    dreq = 1'b0;
    cyc(8);

    // R4: auto-start by count write
    c_sync = 0; c_tc = 0; c_ie = 0; c_ag = 0;
    wr(0, mk_ctrl(0));
    n0 = n_xfer;
    wr(1, 16'd2);
    cyc(6);
    check(!active && n_xfer == n0, "R4 count write without auto-start", active, 0);
    c_ag = 1;
    wr(0, mk_ctrl(0));
    exp_src = 20'h0; exp_dst = 20'h0;
    c_ss = 1; c_ds = 1; c_w = 0;
    wr(0, mk_ctrl(0));
    exp_src = 20'h0; exp_dst = 20'h0;
    wr(2, 16'h0); wr(3, 16'h0); wr(4, 16'h0); wr(5, 16'h0);
    s_step = 1; d_step = 1;
    n0 = n_xfer;
    wr(1, 16'd2);
    check(active, "R4 auto-start sets run", active, 1);
    cyc(25);
    check(n_xfer - n0 == 2 && !active, "R4 auto-started transfers", n_xfer - n0, 2);
    c_ag = 0;

    // R7: each pause source during an unsynchronized run
    c_sync = 0; c_tc = 0; c_ie = 0; c_ss = 1; c_ds = 2; c_w = 1;
    hold = 1'b1;
    go(20'h01000, 20'h02000, 16'd12);
    n0 = n_xfer;
    cyc(10);
    check(n_xfer == n0 && active, "R7 paused before first transfer", n_xfer - n0, 0);
    check(count_left == 12, "R7 count kept while paused", count_left, 12);
    for (int k = 0; k < 4; k++) begin
      int nb;
      hold = 0; refresh = 0; prio_pend = 0; halt = 0;
      cyc(4);
      case (k)
        0: hold = 1'b1;
        1: refresh = 1'b1;
        2: prio_pend = 1'b1;
        default: halt = 1'b1;
      endcase
      cyc(3);
      nb = n_xfer;
      cyc(10);
      check(n_xfer == nb, "R7 no transfer during pause", n_xfer - nb, 0);
      check(count_left == CW'(12 - (n_xfer - n0)), "R7 count matches completed transfers",
            count_left, 12 - (n_xfer - n0));
    end
    hold = 0; refresh = 0; prio_pend = 0; halt = 0;
    cyc(50);
    check(n_xfer - n0 == 12 && !active, "R7 resume completes all", n_xfer - n0, 12);

    // R7: request line gates a synchronized channel
    c_sync = 1; c_tc = 1; dreq = 1'b0;
    go(20'h03000, 20'h04000, 16'd4);
    n0 = n_xfer;
    cyc(15);
    check(n_xfer == n0 && active, "R7 sync waits for dreq", n_xfer - n0, 0);
    dreq = 1'b1;
    cyc(25);
    check(n_xfer - n0 == 4 && !active, "R7 sync runs on dreq", n_xfer - n0, 4);
    dreq = 1'b0;

    report();
    $finish;
  end

endmodule